// File: doc/BRIEF.md
# PRBS-7 Pattern Generator and Checker

This block is the built-in self-test engine for a 10-bit parallel link. A single enable input turns on both halves at once. On the transmit side, while the enable is high, a 2^7-1 pseudo-random word stream replaces the normal parallel transmit data. While the enable is low, the parallel data passes through one register stage. On the receive side, a checker compares incoming 10-bit words against the same sequence and drives one pass flag.

The checker locks onto the sequence by itself. The first valid word after enable loads its state, so the result does not depend on which point of the sequence the far end happens to be sending. A mode input chooses how the pass flag behaves. In live mode the flag reflects every checked word. In sticky mode a single mismatch holds the flag low until the test is restarted by dropping the enable. The block is meant to sit between the parallel transmit/receive buses and a serializer path, so that a loopback or an external pattern source can be checked without software.

Top module: `prbs7_bist`

## Requirements
- R1: While `prbs_en_i` is high, `tx_data_o` presents one new word per clock, one register stage after the edge. Its bits follow b(n) = b(n-7) XOR b(n-6), and word bit 0 carries the earliest sequence bit.
- R2: Each time the enable rises, the generator restarts from its seed. The seven bits assumed to precede the first output bit are, most recent first, 1,0,0,0,0,0,0. The first words after every enable are therefore identical.
- R3: While the enable is low, `tx_data_o` equals `tx_data_i` from the previous edge. While it is high, `tx_data_i` has no effect on `tx_data_o`.
- R4: The generated word stream repeats with a period of 127 words (1270 bits), and no generated word is all zeros.
- R5: After the enable rises, `pass_o` is high from the next edge. The first valid received word seeds the checker and is not compared. The sequence phase of the received stream does not matter.
- R6: With `sticky_i` low, each valid received word after seeding sets `pass_o` on the next edge: high on a match, low on a mismatch. A good word following a bad one brings `pass_o` back high.
- R7: With `sticky_i` high, a mismatch drives `pass_o` low, and it stays low for the rest of that enable period even when later words match.
- R8: A low enable drives `pass_o` low on the next edge and clears both the sticky failure and the seeded state, so the next enable period re-seeds and starts passing.
- R9: While `rx_valid_i` is low, the checker neither advances nor compares, and `pass_o` holds its value whatever `rx_data_i` carries.
- R10: During reset, `tx_data_o` is zero and `pass_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prbs_en_i | input | 1 | Test enable for generator and checker |
| sticky_i | input | 1 | Pass flag mode: 0 live, 1 latched failure |
| tx_data_i | input | 10 | Normal parallel transmit word |
| tx_data_o | output | 10 | Registered transmit word to serializer path |
| rx_valid_i | input | 1 | Received word strobe |
| rx_data_i | input | 10 | Received parallel word, bit 0 earliest |
| pass_o | output | 1 | Check result flag, high = pass |

## Verification
The bench compares the generated words with a bit-level model of the recurrence started from the stated seed. A wrong tap, a reversed bit order or a missing reseed on re-enable shows up as a word mismatch within the first few words. It also compares the words 127 apart, which exposes a state that drifts or skips. The checker is driven from two different sequence phases, with one corrupted word each time. A design that compares the seeding word, or that ties its state to the sender's phase, drops the flag on good data. A design that lets a failure stick in live mode, or clears it in sticky mode, shows the wrong flag on the words after the error. Gaps with junk data and the strobe low catch a checker that advances or compares without a valid word.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;
  localparam int unsigned LFSR_W = 7;
  localparam int unsigned TAP_A  = 7;
  localparam int unsigned TAP_B  = 6;
  localparam logic [LFSR_W-1:0] SEED = 7'h01;

  // history bit 0 is the most recent sequence bit
  function automatic logic next_bit(input logic [LFSR_W-1:0] hist);
    return hist[TAP_A-1] ^ hist[TAP_B-1];
  endfunction
endpackage

// File: rtl/prbs7_adv.sv
module prbs7_adv
  import prbs7_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic [LFSR_W-1:0] hist_i,
  output logic [WORD_W-1:0] word_o,
  output logic [LFSR_W-1:0] hist_o
);
  logic [LFSR_W-1:0] h;
  logic              b;

  always_comb begin
    h      = hist_i;
    b      = 1'b0;
    word_o = '0;
    for (int i = 0; i < WORD_W; i++) begin
      b         = next_bit(h);
      word_o[i] = b;
      h         = {h[LFSR_W-2:0], b};
    end
    hist_o = h;
  end
endmodule

// File: rtl/prbs7_gen.sv
module prbs7_gen
  import prbs7_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o
);
  logic [LFSR_W-1:0] state_q, state_nxt;
  logic [WORD_W-1:0] word;

  prbs7_adv #(.WORD_W(WORD_W)) u_adv (
    .hist_i (state_q),
    .word_o (word),
    .hist_o (state_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
      data_o  <= '0;
    end else if (en_i) begin
      state_q <= state_nxt;
      data_o  <= word;
    end else begin
      state_q <= SEED;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/prbs7_chk.sv
module prbs7_chk
  import prbs7_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sticky_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              seeded_o,
  output logic              pass_o
);
  logic [LFSR_W-1:0] state_q, state_nxt, seed_hist;
  logic [WORD_W-1:0] exp_word;
  logic              mismatch;

  // last LFSR_W bits of the word, most recent first
  always_comb begin
    for (int i = 0; i < LFSR_W; i++) seed_hist[i] = data_i[WORD_W-1-i];
  end

  prbs7_adv #(.WORD_W(WORD_W)) u_adv (
    .hist_i (state_q),
    .word_o (exp_word),
    .hist_o (state_nxt)
  );

  assign mismatch = (data_i != exp_word);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= '0;
      seeded_o <= 1'b0;
      pass_o   <= 1'b0;
    end else if (!en_i) begin
      seeded_o <= 1'b0;
      pass_o   <= 1'b0;
    end else if (!seeded_o) begin
      pass_o <= 1'b1;
      if (valid_i) begin
        state_q  <= seed_hist;
        seeded_o <= 1'b1;
      end
    end else if (valid_i) begin
      // advance on expected state so one bad word does not desync
      state_q <= state_nxt;
      pass_o  <= sticky_i ? (pass_o & ~mismatch) : ~mismatch;
    end
  end
endmodule

// File: rtl/prbs7_bist.sv
module prbs7_bist #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prbs_en_i,
  input  logic              sticky_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic [WORD_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_data_i,
  output logic              pass_o
);
  logic chk_seeded;

  prbs7_gen #(.WORD_W(WORD_W)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (prbs_en_i),
    .data_i (tx_data_i),
    .data_o (tx_data_o)
  );

  prbs7_chk #(.WORD_W(WORD_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (prbs_en_i),
    .sticky_i (sticky_i),
    .valid_i  (rx_valid_i),
    .data_i   (rx_data_i),
    .seeded_o (chk_seeded),
    .pass_o   (pass_o)
  );
endmodule

// File: rtl/prbs7_bist_sva.sv
module prbs7_bist_sva #(
  parameter int unsigned WORD_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prbs_en_i,
  input logic              sticky_i,
  input logic [WORD_W-1:0] tx_data_i,
  input logic [WORD_W-1:0] tx_data_o,
  input logic              seeded_i,
  input logic              pass_o
);
  a_r3_bypass_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prbs_en_i |=> tx_data_o == $past(tx_data_i));

  a_r4_no_zero_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(prbs_en_i) && $past(rst_ni)) |-> tx_data_o != '0);

  a_r7_sticky_holds_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prbs_en_i && sticky_i && seeded_i && !pass_o) |=> !pass_o);

  a_r8_off_forces_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prbs_en_i |=> !pass_o);
endmodule

bind prbs7_bist prbs7_bist_sva #(.WORD_W(WORD_W)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prbs_en_i (prbs_en_i),
  .sticky_i  (sticky_i),
  .tx_data_i (tx_data_i),
  .tx_data_o (tx_data_o),
  .seeded_i  (chk_seeded),
  .pass_o    (pass_o)
);

// File: tb/prbs7_bist_tb.sv
`timescale 1ns/1ps
module prbs7_bist_tb;
  localparam int W = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         prbs_en_i = 1'b0;
  logic         sticky_i = 1'b0;
  logic [W-1:0] tx_data_i = '0;
  logic [W-1:0] tx_data_o;
  logic         rx_valid_i = 1'b0;
  logic [W-1:0] rx_data_i = '0;
  logic         pass_o;

  int checks = 0;
  int errors = 0;
  logic seq [0:2047];
  logic [W-1:0] got [0:159];

  always #5 clk_i = ~clk_i;

  prbs7_bist #(.WORD_W(W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word_at(input int off, input int k);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = seq[7 + off + W*k + i];
    return w;
  endfunction

  task automatic settle();
    @(posedge clk_i);
    #2;
  endtask

  task automatic t_reset();
    #2;
    check(tx_data_o == '0, "R10 tx", tx_data_o, 0);
    check(pass_o == 1'b0, "R10 pass", pass_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_bypass();
    logic [W-1:0] v [4] = '{10'h2A5, 10'h3FF, 10'h000, 10'h1C3};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      tx_data_i = v[i];
      settle();
      check(tx_data_o == v[i], "R3 bypass", tx_data_o, v[i]);
    end
  endtask

  task automatic t_gen();
    @(negedge clk_i);
    prbs_en_i = 1'b1;
    for (int k = 0; k < 140; k++) begin
      settle();
      got[k] = tx_data_o;
      check(tx_data_o == word_at(0, k), "R1 word", tx_data_o, word_at(0, k));
      check(tx_data_o != '0, "R4 nonzero", tx_data_o, 1);
      if (k >= 127) check(got[k] == got[k-127], "R4 period", got[k], got[k-127]);
      @(negedge clk_i);
      tx_data_i = W'(k * 37 + 5); // R3: ignored while enabled
    end
    prbs_en_i = 1'b0;
    settle();
  endtask

  task automatic t_restart();
    @(negedge clk_i);
    prbs_en_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      settle();
      check(tx_data_o == word_at(0, k), "R2 restart", tx_data_o, word_at(0, k));
    end
    @(negedge clk_i);
    prbs_en_i = 1'b0;
    settle();
  endtask

  task automatic send(input logic [W-1:0] w, input logic exp, input string req);
    @(negedge clk_i);
    rx_valid_i = 1'b1;
    rx_data_i  = w;
    settle();
    check(pass_o == exp, req, pass_o, exp);
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic t_live(input int off);
    @(negedge clk_i);
    sticky_i  = 1'b0;
    prbs_en_i = 1'b1;
    settle();
    check(pass_o == 1'b1, "R5 seeding", pass_o, 1);
    for (int k = 0; k < 40; k++) begin
      if (k == 20) send(word_at(off, k) ^ 10'h008, 1'b0, "R6 error");
      else send(word_at(off, k), 1'b1, "R6 live");
      if (k == 10) begin
        for (int g = 0; g < 3; g++) begin
          @(negedge clk_i);
          rx_data_i = 10'h155;
          settle();
          check(pass_o == 1'b1, "R9 gap", pass_o, 1);
        end
      end
    end
    @(negedge clk_i);
    prbs_en_i = 1'b0;
    settle();
    check(pass_o == 1'b0, "R8 off", pass_o, 0);
  endtask

  task automatic t_sticky(input int off, input int off2);
    @(negedge clk_i);
    sticky_i  = 1'b1;
    prbs_en_i = 1'b1;
    for (int k = 0; k < 30; k++) begin
      if (k == 8) send(word_at(off, k) ^ 10'h200, 1'b0, "R7 error");
      else send(word_at(off, k), k < 8, "R7 sticky");
    end
    @(negedge clk_i);
    prbs_en_i = 1'b0;
    settle();
    check(pass_o == 1'b0, "R8 off", pass_o, 0);
    @(negedge clk_i);
    prbs_en_i = 1'b1;
    for (int k = 0; k < 12; k++) send(word_at(off2, k), 1'b1, "R8 cleared");
    @(negedge clk_i);
    prbs_en_i = 1'b0;
    sticky_i  = 1'b0;
    settle();
  endtask

  initial begin
    for (int i = 0; i < 6; i++) seq[i] = 1'b0;
    seq[6] = 1'b1;
    for (int n = 7; n < 2048; n++) seq[n] = seq[n-7] ^ seq[n-6];
    t_reset();
    t_bypass();
    t_gen();
    t_restart();
    t_live(33);
    t_live(91);
    t_sticky(5, 58);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule